// File: doc/BRIEF.md
# Seven-Slot Pixel Serializer for Three or Four Display Lanes

The block turns a stream of RGB pixels with their sync and enable bits into bit-serial lane traffic for a flat-panel link. It runs on a single fast bit clock. Every pixel period is seven bit clocks long. Each period carries one 7-bit word on each data lane and a matching lane clock pattern.

A packing selector picks one of three lane layouts:
- an 18-bit layout on three lanes;
- a 24-bit layout that sends the upper six bits of each colour on lanes 0 to 2;
- a 24-bit layout that keeps lanes 0 to 2 identical to the 18-bit layout and puts the top two bits of each colour on lane 3.

A mirror input reverses the slot order on every data lane.

The pixel input is a valid/ready stream. Ready is high for one bit clock in every seven: the last slot of the current period. A pixel is taken on the edge where valid and ready are both high. The edge that ends each period always starts a new word, so back-pressure is fixed by the slot timing and cannot be stretched. If valid is low at that edge, a blank word (all zero, controls included) is sent for the whole period. The selector and mirror inputs are sampled on that same edge only.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: `pix_ready` is high only during slot 6 of each seven-clock period. A pixel is accepted on the rising edge where `pix_valid` and `pix_ready` are both high. The lane bit for slot s is on `lane_dout` after the s-th edge following the accepting edge (s = 0 after the accepting edge itself). `pix_ready` rises again six edges after the accepting edge.
- R2: With `map_sel` = 2'b00, the words are built from the low six bits of each colour; `pix_rgb` is {R[23:16], G[15:8], B[7:0]}. Slot-by-slot contents, slots 0 to 6:
  - lane 0: G0, R5, R4, R3, R2, R1, R0;
  - lane 1: B1, B0, G5..G1;
  - lane 2: DE, VS, HS, B5..B2;
  - lane 3 is low in every slot, and colour bits 7:6 have no effect.
- R3: With `map_sel` = 2'b01, slots 0 to 6 carry:
  - lane 0: G2, R7..R2;
  - lane 1: B3, B2, G7..G3;
  - lane 2: DE, VS, HS, B7..B4;
  - lane 3: 0, B1, B0, G1, G0, R1, R0.
- R4: With `map_sel` = 2'b10, lanes 0 to 2 match R2 exactly, and lane 3 carries 0, B7, B6, G7, G6, R7, R6 in slots 0 to 6.
- R5: `pix_ctl[0]` is horizontal sync (HS), `pix_ctl[1]` is vertical sync (VS) and `pix_ctl[2]` is data enable (DE), placed as listed in R2 to R4. The fourth control position (lane 3, slot 0) is always 0.
- R6: With `mirror_en` high at the accepting edge, every lane sends its word in slot order 6 down to 0.
- R7: If `pix_valid` is low at the edge that ends slot 6, every data lane is low for the whole next period.
- R8: While `rst` is high (synchronous, active high), all data lanes are low, `pix_ready` is low, the slot count is 0 and `lane_clk` is high.
- R9: Changes to `map_sel` or `mirror_en` that occur between accepting edges do not alter the word already being sent.
- R10: `lane_clk` follows 1,1,0,0,0,1,1 over slots 0 to 6. It falls only entering slot 2 and rises only entering slot 5.
- R11: `map_sel` = 2'b11 packs exactly as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven per pixel |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Pixel present on pix_rgb/pix_ctl |
| pix_ready | output | 1 | High in slot 6; pixel taken when valid also high |
| pix_rgb | input | 24 | {R, G, B}, 8 bits each |
| pix_ctl | input | 3 | {DE, VS, HS} |
| map_sel | input | 2 | Lane packing layout select |
| mirror_en | input | 1 | Reverse slot order on all lanes |
| lane_dout | output | 4 | Serial data lanes 3..0 |
| lane_clk | output | 1 | Serial lane clock pattern |

## Verification
Each lane result is due on a fixed schedule. The slot-s bit is on the lanes s+1 rising edges after the bench drives a pixel in the half-cycle where ready is high. The bench therefore drives on a falling edge and then samples the lanes and `lane_clk` on each of the next seven falling edges, which puts sample k squarely inside slot k. Ready is sampled on those same falling edges, and it must be low for the first six samples and high on the seventh. The seventh sample is also where the next pixel is driven, so the deserializer and the stimulus never drift apart. For the mid-period change case, the selector and mirror inputs are flipped after the third sample. The remaining four slots must still match the word that was latched at the accepting edge.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOT_N = 7;
  localparam int LANE_N = 4;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int CTL_W  = 3;
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam int SUB_W  = 6;

  typedef enum logic [1:0] {
    MAP_NARROW      = 2'b00,
    MAP_WIDE_MSB    = 2'b01,
    MAP_WIDE_COMPAT = 2'b10,
    MAP_RSVD        = 2'b11
  } map_mode_e;

  typedef logic [SLOT_N-1:0] slot_word_t;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] blu;
    logic            de;
    logic            vs;
    logic            hs;
  } pixel_t;

  // bit s is the lane clock level during slot s
  localparam slot_word_t LCLK_PATTERN = 7'b1100011;

  function automatic slot_word_t reverse_word(input slot_word_t w);
    slot_word_t r;
    for (int i = 0; i < SLOT_N; i++) r[i] = w[SLOT_N-1-i];
    return r;
  endfunction
endpackage

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer
  import lvds_ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic capture,
  output logic lane_clk
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_nxt;

  assign capture  = (slot_q == LAST_SLOT) && !rst;
  assign slot_nxt = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      lane_clk <= LCLK_PATTERN[0];
    end else begin
      slot_q   <= slot_nxt;
      lane_clk <= LCLK_PATTERN[slot_nxt];
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST_SLOT); // R1
  AST_CAPTURE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture); // R1
  AST_LCLK_RISE_SLOT: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_clk) |-> (slot_q == SLOT_W'(5))); // R10
  AST_LCLK_FALL_SLOT: assert property (@(posedge clk) disable iff (rst)
    $fell(lane_clk) |-> (slot_q == SLOT_W'(2))); // R10
endmodule

// File: rtl/lvds_lane_packer.sv
module lvds_lane_packer
  import lvds_ser_pkg::*;
(
  input  pixel_t                        pix,
  input  map_mode_e                     mode,
  output logic [LANE_N-1:0][SLOT_N-1:0] words
);
  logic [SUB_W-1:0] r6, g6, b6;
  logic [1:0]       r2, g2, b2;
  logic             wide_msb, compat;

  always_comb begin
    wide_msb = (mode == MAP_WIDE_MSB);
    compat   = (mode == MAP_WIDE_COMPAT);
    r6 = wide_msb ? pix.red[CH_W-1:2] : pix.red[SUB_W-1:0];
    g6 = wide_msb ? pix.grn[CH_W-1:2] : pix.grn[SUB_W-1:0];
    b6 = wide_msb ? pix.blu[CH_W-1:2] : pix.blu[SUB_W-1:0];
    r2 = compat ? pix.red[CH_W-1:CH_W-2] : pix.red[1:0];
    g2 = compat ? pix.grn[CH_W-1:CH_W-2] : pix.grn[1:0];
    b2 = compat ? pix.blu[CH_W-1:CH_W-2] : pix.blu[1:0];

    words = '0;
    // lane 0: one green bit then red descending
    words[0][0] = g6[0];
    for (int k = 1; k < SLOT_N; k++) words[0][k] = r6[6-k];
    // lane 1: two blue bits then green descending
    words[1][0] = b6[1];
    words[1][1] = b6[0];
    for (int k = 2; k < SLOT_N; k++) words[1][k] = g6[7-k];
    // lane 2: controls then blue descending
    words[2][0] = pix.de;
    words[2][1] = pix.vs;
    words[2][2] = pix.hs;
    for (int k = 3; k < SLOT_N; k++) words[2][k] = b6[8-k];
    // lane 3: only in the 24-bit layouts
    if (wide_msb || compat) begin
      words[3][0] = 1'b0;
      words[3][1] = b2[1];
      words[3][2] = b2[0];
      words[3][3] = g2[1];
      words[3][4] = g2[0];
      words[3][5] = r2[1];
      words[3][6] = r2[0];
    end
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
  import lvds_ser_pkg::*;
#(
  parameter int LANES = LANE_N
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       mirror,
  input  logic [LANES-1:0][SLOT_N-1:0] words,
  output logic [LANES-1:0]           dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    slot_word_t sh_q;
    always_ff @(posedge clk) begin
      if (rst)       sh_q <= '0;
      else if (load) sh_q <= mirror ? reverse_word(words[l]) : words[l];
      else           sh_q <= {1'b0, sh_q[SLOT_N-1:1]};
    end
    assign dout[l] = sh_q[0];
  end
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [PIX_W-1:0]     pix_rgb,
  input  logic [CTL_W-1:0]     pix_ctl,
  input  logic [1:0]           map_sel,
  input  logic                 mirror_en,
  output logic [LANE_N-1:0]    lane_dout,
  output logic                 lane_clk
);
  logic                        capture;
  pixel_t                      pix_in;
  logic [LANE_N-1:0][SLOT_N-1:0] words;

  lvds_slot_timer u_timer (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .lane_clk (lane_clk)
  );

  assign pix_ready = capture;
  // blank word when no pixel is offered at the capture edge
  assign pix_in = pix_valid ? pixel_t'({pix_rgb, pix_ctl}) : '0;

  lvds_lane_packer u_packer (
    .pix   (pix_in),
    .mode  (map_mode_e'(map_sel)),
    .words (words)
  );

  lvds_lane_shifter #(.LANES(LANE_N)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (capture),
    .mirror (mirror_en),
    .words  (words),
    .dout   (lane_dout)
  );

  AST_RESET_LANES_LOW: assert property (@(posedge clk)
    rst |=> (lane_dout == '0)); // R8
  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && !pix_valid) |=> (lane_dout == '0)); // R7
  AST_NARROW_LANE3_LOW: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && (map_sel == 2'b00 || map_sel == 2'b11)) |=> !lane_dout[3]); // R2
endmodule

// File: tb/tb_lvds_pixel_serializer.sv
`timescale 1ns/1ps
module tb_lvds_pixel_serializer;
  logic        clk = 1'b0;
  logic        rst;
  logic        pix_valid;
  logic        pix_ready;
  logic [23:0] pix_rgb;
  logic [2:0]  pix_ctl;
  logic [1:0]  map_sel;
  logic        mirror_en;
  logic [3:0]  lane_dout;
  logic        lane_clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  lvds_pixel_serializer dut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_rgb(pix_rgb), .pix_ctl(pix_ctl), .map_sel(map_sel),
    .mirror_en(mirror_en), .lane_dout(lane_dout), .lane_clk(lane_clk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] rev7(input logic [6:0] w);
    logic [6:0] r;
    for (int i = 0; i < 7; i++) r[i] = w[6-i];
    return r;
  endfunction

  // expected word, bit s = slot s, from the requirement tables
  function automatic logic [6:0] exp_word(input int lane, input logic [1:0] mode,
                                          input logic [23:0] rgb, input logic [2:0] ctl);
    logic [7:0] r, g, b;
    logic hs, vs, de;
    r = rgb[23:16]; g = rgb[15:8]; b = rgb[7:0];
    hs = ctl[0]; vs = ctl[1]; de = ctl[2];
    if (mode == 2'b01) begin
      case (lane)
        0: return {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
        1: return {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
        2: return {b[4], b[5], b[6], b[7], hs, vs, de};
        default: return {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
      endcase
    end
    case (lane)
      0: return {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
      1: return {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
      2: return {b[2], b[3], b[4], b[5], hs, vs, de};
      default: return (mode == 2'b10) ? {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0} : 7'b0;
    endcase
  endfunction

  // entered at a falling edge inside slot 6; leaves at the next slot-6 falling edge
  task automatic run_pixel(input string req, input logic v, input logic [23:0] rgb,
                           input logic [2:0] ctl, input logic [1:0] mode,
                           input logic mir, input bit flip_mid);
    logic [3:0][6:0] got;
    logic [6:0]      clk_seen;
    logic [6:0]      rdy_seen;
    check("R1 ready at entry", 32'(pix_ready), 32'd1);
    pix_valid = v; pix_rgb = rgb; pix_ctl = ctl; map_sel = mode; mirror_en = mir;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) got[l][s] = lane_dout[l];
      clk_seen[s] = lane_clk;
      rdy_seen[s] = pix_ready;
      if (s == 0) begin
        pix_valid = 1'b0;
        pix_rgb = ~rgb;
        pix_ctl = ~ctl;
      end
      if (flip_mid && s == 2) begin
        map_sel = mode ^ 2'b11;
        mirror_en = ~mir;
      end
    end
    for (int l = 0; l < 4; l++) begin
      logic [6:0] e;
      e = v ? exp_word(l, mode, rgb, ctl) : 7'b0;
      if (mir) e = rev7(e);
      check(req, 32'(got[l]), 32'(e));
    end
    check("R10 lane clock", 32'(clk_seen), 32'h63);
    check("R1 ready slot6 only", 32'(rdy_seen), 32'h40);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst = 1'b1; pix_valid = 1'b0; pix_rgb = '0; pix_ctl = '0; map_sel = '0; mirror_en = 1'b0;
    repeat (4) @(negedge clk);
    // R8 reset state
    check("R8 lanes low", 32'(lane_dout), 32'd0);
    check("R8 ready low", 32'(pix_ready), 32'd0);
    check("R8 lane clk high", 32'(lane_clk), 32'd1);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) @(negedge clk);
    check("R8 count from 0 to ready", 32'(pix_ready), 32'd1);

    // directed layouts
    run_pixel("R2 narrow",       1'b1, 24'hC3_5A_A5, 3'b101, 2'b00, 1'b0, 0);
    run_pixel("R2 bits 7:6 ignored", 1'b1, 24'hFF_FF_FF, 3'b000, 2'b00, 1'b0, 0);
    run_pixel("R3 msb aligned",  1'b1, 24'h81_42_24, 3'b010, 2'b01, 1'b0, 0);
    run_pixel("R4 compat",       1'b1, 24'hC0_80_40, 3'b001, 2'b10, 1'b0, 0);
    run_pixel("R5 hs only",      1'b1, 24'h00_00_00, 3'b001, 2'b01, 1'b0, 0);
    run_pixel("R5 vs only",      1'b1, 24'h00_00_00, 3'b010, 2'b10, 1'b0, 0);
    run_pixel("R5 de only",      1'b1, 24'h00_00_00, 3'b100, 2'b00, 1'b0, 0);
    run_pixel("R6 mirror narrow", 1'b1, 24'h12_34_56, 3'b110, 2'b00, 1'b1, 0);
    run_pixel("R6 mirror msb",   1'b1, 24'hFE_01_7F, 3'b011, 2'b01, 1'b1, 0);
    run_pixel("R7 blank word",   1'b0, 24'hFF_FF_FF, 3'b111, 2'b01, 1'b0, 0);
    run_pixel("R9 mid change",   1'b1, 24'hA5_3C_96, 3'b111, 2'b01, 1'b0, 1);
    run_pixel("R9 mid change mirror", 1'b1, 24'h5A_C3_69, 3'b010, 2'b10, 1'b1, 1);
    run_pixel("R11 reserved code", 1'b1, 24'hC3_5A_A5, 3'b101, 2'b11, 1'b0, 0);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      run_pixel(m == 2'b01 ? "R3 random" : (m == 2'b10 ? "R4 random" :
                (m == 2'b11 ? "R11 random" : "R2 random")),
                ($urandom_range(0, 7) != 0), 24'($urandom), 3'($urandom),
                m, 1'($urandom), ($urandom_range(0, 9) == 0));
    end

    // R8 reset mid-period
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid-run lanes low", 32'(lane_dout), 32'd0);
    check("R8 mid-run ready low", 32'(pix_ready), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule